// File: doc/BRIEF.md
# Quadrature Position Decoder with Gated Index Reset

This block turns two already-filtered quadrature phase signals and an index marker into a signed-free, W-bit position count. Every edge on either phase moves the count by one, so one full electrical cycle of the encoder gives four counts. The phase relationship gives the direction. A swap control exchanges the two phases before decoding. This lets a board with crossed wiring count in the intended sense.

Two counting modes are selected by a mode input. In index-reset mode, a rising edge on the index input reloads the count. This happens only when the decoded phase levels equal a selected 2-bit gate pattern. Moving forward, the count reloads to zero. Moving backward, it reloads to the ceiling. In preset mode the index is ignored, and the count runs between zero and a ceiling value, wrapping at either end. The ceiling is captured from its input only while the block is disabled. Changes made while counting therefore cannot disturb a run in progress.

The block reports four single-cycle event pulses: direction change, reset or wrap while counting up, reset or wrap while counting down, and phase error. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `qdec_core`

## Requirements
- R1: With swap off, the decoded pair {A,B} moving 00→10→11→01→00 is forward. Each such edge, sampled at a rising clock edge with enable high, adds one to `position` at that same clock edge, and `dir_up` reads 1.
- R2: The reverse sequence subtracts one per edge and drives `dir_up` to 0. A valid step whose direction differs from the previous `dir_up` raises `ev_dir_change` for one cycle.
- R3: When `swap_ab` is 1, A and B exchange roles before decoding, so a physical forward sequence counts down.
- R4: If both decoded phases change in the same sample, `ev_phase_err` pulses for one cycle and `position` is unchanged.
- R5: In index-reset mode (`index_reset_mode`=1), a rising edge of `index` resets the count only if the decoded {A,B} equals `gate_sel`. The gate codes are 0=A low B low, 1=A low B high, 2=A high B low, 3=A high B high. The count becomes 0 with an `ev_reset_up` pulse when `dir_up` (after any step in that cycle) is 1. Otherwise it becomes the ceiling, with an `ev_reset_down` pulse. A held-high index does not reset again, and a non-matching pattern does not reset.
- R6: In preset mode (`index_reset_mode`=0), counting up from the ceiling gives 0 and pulses `ev_reset_up`. Counting down from 0 gives the ceiling and pulses `ev_reset_down`.
- R7: The ceiling is taken from `ceiling` at each clock edge where `enable` is 0. Changes while `enable` is 1 have no effect on wrapping or reset values.
- R8: While `enable` is 0, `position` holds and no event pulses. Phase history still tracks the inputs, so re-enabling causes no spurious step.
- R9: The asynchronous active-low reset clears `position` to 0, sets `dir_up` to 1 and clears all event outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counting enable; ceiling loads while low |
| index_reset_mode | input | 1 | 1 = reset on gated index, 0 = preset/wrap mode |
| swap_ab | input | 1 | Exchange phases A and B before decoding |
| gate_sel | input | 2 | Required {A,B} level pattern for an index reset |
| ceiling | input | W | Upper count limit, captured while disabled |
| phase_a | input | 1 | Filtered phase A |
| phase_b | input | 1 | Filtered phase B |
| index | input | 1 | Filtered index marker |
| position | output | W | Current count |
| dir_up | output | 1 | Direction of the last valid step, 1 = up |
| ev_dir_change | output | 1 | One-cycle pulse on a direction reversal |
| ev_reset_up | output | 1 | One-cycle pulse on reset/wrap to 0 while moving up |
| ev_reset_down | output | 1 | One-cycle pulse on reset/wrap to ceiling while moving down |
| ev_phase_err | output | 1 | One-cycle pulse on an illegal double-phase change |

## Verification
Each result is due at the first rising clock edge that samples the changed phase or index level. `position`, `dir_up` and every event pulse are registered there, with no further pipeline delay. The ceiling takes effect from the first edge sampled with enable low. The bench changes inputs on a falling edge and compares every output at the next falling edge, so each check sees exactly the one edge that the stimulus drove. Event pulses are also checked to be gone one vector later.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef struct packed {
    logic step;
    logic up;
    logic perr;
  } qdec_step_t;

  // Successor of a phase pair in the forward direction ({A,B}).
  function automatic logic [1:0] fwd_next(input logic [1:0] ab);
    case (ab)
      2'b00:   fwd_next = 2'b10;
      2'b10:   fwd_next = 2'b11;
      2'b11:   fwd_next = 2'b01;
      default: fwd_next = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/qdec_phase_track.sv
module qdec_phase_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap_ab,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       index,
  output logic [1:0] ab_now,
  output logic [1:0] ab_prev,
  output logic       idx_rise
);
  logic idx_q;

  assign ab_now   = swap_ab ? {phase_b, phase_a} : {phase_a, phase_b};
  assign idx_rise = index & ~idx_q;

  // History is kept regardless of enable so re-enabling sees no stale edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev <= 2'b00;
      idx_q   <= 1'b0;
    end else begin
      ab_prev <= ab_now;
      idx_q   <= index;
    end
  end
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic [1:0] ab_prev,
  input  logic [1:0] ab_now,
  output qdec_step_t step_o
);
  logic [1:0] diff;

  always_comb begin
    diff        = ab_prev ^ ab_now;
    step_o.perr = (diff == 2'b11);
    step_o.step = (diff == 2'b01) || (diff == 2'b10);
    step_o.up   = (ab_now == fwd_next(ab_prev));
  end
endmodule

// File: rtl/qdec_position.sv
module qdec_position
  import qdec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         index_reset_mode,
  input  logic [W-1:0] ceiling,
  input  qdec_step_t   step_i,
  input  logic         idx_hit,
  output logic [W-1:0] position,
  output logic         dir_up,
  output logic         ev_dir_change,
  output logic         ev_reset_up,
  output logic         ev_reset_down,
  output logic         ev_phase_err
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] ceil_q;
  logic [W-1:0] pos_n;
  logic         dir_n, chg_n, rup_n, rdn_n, perr_n;

  always_comb begin
    pos_n  = position;
    dir_n  = dir_up;
    chg_n  = 1'b0;
    rup_n  = 1'b0;
    rdn_n  = 1'b0;
    perr_n = 1'b0;
    if (enable) begin
      if (step_i.perr) begin
        perr_n = 1'b1;
      end else if (step_i.step) begin
        dir_n = step_i.up;
        chg_n = (step_i.up != dir_up);
        if (step_i.up) begin
          if (!index_reset_mode && position == ceil_q) begin
            pos_n = '0;
            rup_n = 1'b1;
          end else begin
            pos_n = position + ONE;
          end
        end else begin
          if (!index_reset_mode && position == '0) begin
            pos_n = ceil_q;
            rdn_n = 1'b1;
          end else begin
            pos_n = position - ONE;
          end
        end
      end
      if (index_reset_mode && idx_hit) begin
        pos_n = dir_n ? '0 : ceil_q;
        rup_n = dir_n;
        rdn_n = ~dir_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q        <= '1;
      position      <= '0;
      dir_up        <= 1'b1;
      ev_dir_change <= 1'b0;
      ev_reset_up   <= 1'b0;
      ev_reset_down <= 1'b0;
      ev_phase_err  <= 1'b0;
    end else begin
      if (!enable) ceil_q <= ceiling;
      position      <= pos_n;
      dir_up        <= dir_n;
      ev_dir_change <= chg_n;
      ev_reset_up   <= rup_n;
      ev_reset_down <= rdn_n;
      ev_phase_err  <= perr_n;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(position)); // R8
  AST_RESET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_reset_up, ev_reset_down})); // R5
  AST_UP_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset_up |-> position == '0); // R6
  AST_DOWN_RESET_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset_down |-> position == ceil_q); // R5
  AST_PERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_phase_err && !ev_reset_up && !ev_reset_down) |-> $stable(position)); // R4
  AST_CEIL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(ceil_q)); // R7
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_reset_up && !ev_reset_down) |->
      (position == $past(position) || position == $past(position) + ONE ||
       position == $past(position) - ONE)); // R1
endmodule

// File: rtl/qdec_core.sv
module qdec_core
  import qdec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         index_reset_mode,
  input  logic         swap_ab,
  input  logic [1:0]   gate_sel,
  input  logic [W-1:0] ceiling,
  input  logic         phase_a,
  input  logic         phase_b,
  input  logic         index,
  output logic [W-1:0] position,
  output logic         dir_up,
  output logic         ev_dir_change,
  output logic         ev_reset_up,
  output logic         ev_reset_down,
  output logic         ev_phase_err
);
  logic [1:0] ab_now, ab_prev;
  logic       idx_rise, idx_hit;
  qdec_step_t step;

  qdec_phase_track u_track (
    .clk(clk), .rst_n(rst_n), .swap_ab(swap_ab),
    .phase_a(phase_a), .phase_b(phase_b), .index(index),
    .ab_now(ab_now), .ab_prev(ab_prev), .idx_rise(idx_rise)
  );

  qdec_step_decode u_dec (
    .ab_prev(ab_prev), .ab_now(ab_now), .step_o(step)
  );

  assign idx_hit = idx_rise && (ab_now == gate_sel);

  qdec_position #(.W(W)) u_pos (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .index_reset_mode(index_reset_mode), .ceiling(ceiling),
    .step_i(step), .idx_hit(idx_hit),
    .position(position), .dir_up(dir_up),
    .ev_dir_change(ev_dir_change), .ev_reset_up(ev_reset_up),
    .ev_reset_down(ev_reset_down), .ev_phase_err(ev_phase_err)
  );

  AST_PERR_NOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_phase_err |-> !ev_dir_change); // R4
endmodule

// File: tb/test_qdec_core.sv
module test_qdec_core;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         index_reset_mode = 1'b1;
  logic         swap_ab = 1'b0;
  logic [1:0]   gate_sel = 2'd3;
  logic [W-1:0] ceiling = 32'd100;
  logic         phase_a = 1'b0;
  logic         phase_b = 1'b0;
  logic         index = 1'b0;
  logic [W-1:0] position;
  logic         dir_up, ev_dir_change, ev_reset_up, ev_reset_down, ev_phase_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qdec_core #(.W(W)) i_qdec_core (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .index_reset_mode(index_reset_mode), .swap_ab(swap_ab),
    .gate_sel(gate_sel), .ceiling(ceiling),
    .phase_a(phase_a), .phase_b(phase_b), .index(index),
    .position(position), .dir_up(dir_up),
    .ev_dir_change(ev_dir_change), .ev_reset_up(ev_reset_up),
    .ev_reset_down(ev_reset_down), .ev_phase_err(ev_phase_err)
  );

  // {a, b, idx, position, dir_up, {dir_change, reset_up, reset_down, phase_err}}
  localparam logic [39:0] VEC [16] = '{
    {1'b1, 1'b0, 1'b0, 32'd1,   1'b1, 4'b0000},
    {1'b1, 1'b1, 1'b0, 32'd2,   1'b1, 4'b0000},
    {1'b0, 1'b1, 1'b0, 32'd3,   1'b1, 4'b0000},
    {1'b0, 1'b0, 1'b0, 32'd4,   1'b1, 4'b0000},
    {1'b1, 1'b0, 1'b0, 32'd5,   1'b1, 4'b0000},
    {1'b0, 1'b0, 1'b0, 32'd4,   1'b0, 4'b1000},
    {1'b0, 1'b1, 1'b0, 32'd3,   1'b0, 4'b0000},
    {1'b1, 1'b1, 1'b0, 32'd2,   1'b0, 4'b0000},
    {1'b1, 1'b1, 1'b1, 32'd100, 1'b0, 4'b0010},
    {1'b1, 1'b1, 1'b0, 32'd100, 1'b0, 4'b0000},
    {1'b0, 1'b1, 1'b0, 32'd101, 1'b1, 4'b1000},
    {1'b1, 1'b0, 1'b0, 32'd101, 1'b1, 4'b0001},
    {1'b1, 1'b1, 1'b0, 32'd102, 1'b1, 4'b0000},
    {1'b1, 1'b1, 1'b1, 32'd0,   1'b1, 4'b0100},
    {1'b1, 1'b1, 1'b0, 32'd0,   1'b1, 4'b0000},
    {1'b0, 1'b1, 1'b1, 32'd1,   1'b1, 4'b0000}
  };

  function automatic logic [3:0] evs();
    return {ev_dir_change, ev_reset_up, ev_reset_down, ev_phase_err};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after one rising edge.
  task automatic apply(input logic a, input logic b, input logic idx);
    phase_a = a;
    phase_b = b;
    index   = idx;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mv(input bit fwd);
    logic [1:0] cur, nxt;
    cur = {phase_a, phase_b};
    if (fwd) nxt = qdec_pkg::fwd_next(cur);
    else begin
      case (cur)
        2'b00:   nxt = 2'b01;
        2'b01:   nxt = 2'b11;
        2'b11:   nxt = 2'b10;
        default: nxt = 2'b00;
      endcase
    end
    apply(nxt[1], nxt[0], 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 position", 64'(position), 64'd0);
    chk("R9 dir_up", 64'(dir_up), 64'd1);
    chk("R9 events", 64'(evs()), 64'd0);
    rst_n = 1'b1;
    apply(1'b0, 1'b0, 1'b0);  // ceiling 100 captured while disabled
    enable = 1'b1;

    // Table: R1 R2 R4 R5 in index-reset mode, gate code 3
    foreach (VEC[i]) begin
      apply(VEC[i][39], VEC[i][38], VEC[i][37]);
      chk($sformatf("R1/R2/R4/R5 vec%0d position", i), 64'(position), 64'(VEC[i][36:5]));
      chk($sformatf("R2 vec%0d dir_up", i), 64'(dir_up), 64'(VEC[i][4]));
      chk($sformatf("R2/R4/R5 vec%0d events", i), 64'(evs()), 64'(VEC[i][3:0]));
    end

    // R6 preset mode, ceiling 5 (R7 load while disabled, R8 hold)
    enable = 1'b0; index_reset_mode = 1'b0; ceiling = 32'd5;
    apply(1'b0, 1'b1, 1'b0);
    chk("R8 hold while loading ceiling", 64'(position), 64'd1);
    enable = 1'b1;
    mv(1); mv(1); mv(1); mv(1);
    chk("R6 count to ceiling", 64'(position), 64'd5);
    mv(1);
    chk("R6 wrap up to zero", 64'(position), 64'd0);
    chk("R6 wrap up event", 64'(evs()), 64'b0100);
    mv(0);
    chk("R6 wrap down to ceiling", 64'(position), 64'd5);
    chk("R6 wrap down events", 64'(evs()), 64'b1010);

    // R7 ceiling change while enabled is ignored
    ceiling = 32'd50;
    for (int k = 0; k < 5; k++) mv(0);
    chk("R7 counted to zero", 64'(position), 64'd0);
    mv(0);
    chk("R7 old ceiling still used", 64'(position), 64'd5);
    chk("R7 down wrap event", 64'(evs()), 64'b0010);

    // R8 disabled: no counting, no events
    enable = 1'b0;
    mv(1);
    chk("R8 no event while disabled", 64'(evs()), 64'd0);
    mv(1); mv(1);
    chk("R8 position held", 64'(position), 64'd5);
    enable = 1'b1;
    mv(1);
    chk("R7 reloaded ceiling allows 6", 64'(position), 64'd6);

    // R3 swap reverses counting
    enable = 1'b0; swap_ab = 1'b1; index_reset_mode = 1'b1;
    apply(phase_a, phase_b, 1'b0);
    enable = 1'b1;
    mv(1);
    chk("R3 swapped forward counts down", 64'(position), 64'd5);
    chk("R3 swapped dir_up", 64'(dir_up), 64'd0);

    // R5 gate code 2 (A high, B low), moving down -> ceiling
    enable = 1'b0; swap_ab = 1'b0; gate_sel = 2'd2;
    apply(1'b1, 1'b0, 1'b0);
    enable = 1'b1;
    apply(1'b1, 1'b0, 1'b1);
    chk("R5 gate 2 down reset to ceiling", 64'(position), 64'd50);
    chk("R5 gate 2 down event", 64'(evs()), 64'b0010);
    apply(1'b1, 1'b0, 1'b1);
    chk("R5 held index no repeat", 64'(evs()), 64'd0);
    chk("R5 held index position", 64'(position), 64'd50);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule